// File: doc/BRIEF.md
# Two-Class Interrupt Index and Vector Reader

This block arbitrates a vector of interrupt request lines into two separate classes, a normal class and a fast class. Every request line sets a sticky pending latch. For each class the block keeps one registered arbitration result. Software can read that result as a channel index or as a handler address taken from a configured vector table. The read path is a plain 32-bit register bus.

Reading a class's index or vector register consumes the request that the read returned. From the next clock cycle both registers of that class show the next pending request. When a class has nothing left, its index reads zero and its vector register returns a configurable phantom address. The class of each channel, the channel enables, the vector table and the phantom address are all static configuration inputs.

The bus has no back-pressure. A read completes in the same cycle it is presented, with `bus_rdata` driven combinationally from registered state, and a write is accepted and discarded.

Top module: `intvec_reader`

## Requirements
- R1: After reset both index registers read 0 and both vector registers read `phantom_addr`.
- R2: The normal index register (offset 0x00) and the fast index register (offset 0x04) report channel c as the value c+1 in bits 7:0. The reported channel is the lowest-numbered pending and eligible channel. Bits 31:8 always read 0.
- R3: When a class has no eligible pending channel, its index register reads 0 and its vector register returns `phantom_addr`.
- R4: The normal vector register (offset 0x70) and the fast vector register (offset 0x74) return the vector table entry of the channel that the class's index register reports at the same time.
- R5: A read of either the index register or the vector register of a class clears the pending latch of the reported channel. From the next cycle, both registers of that class reflect the next pending request.
- R6: Reading one class never changes the result of the other class.
- R7: A channel takes part only in the class chosen by its `fast_sel` bit (1 = fast, 0 = normal), and only while its `chan_en` bit is 1. A disabled channel stays pending.
- R8: Writes change no state. A read of any offset other than 0x00, 0x04, 0x70 and 0x74 returns 0 and consumes nothing.
- R9: A request pulse of one cycle stays pending until a read returns it. A request that is still high during the read that returns it stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data (discarded) |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| req | input | N_CH | Request lines, one per channel |
| fast_sel | input | N_CH | Class of each channel, 1 = fast |
| chan_en | input | N_CH | Enable of each channel |
| vec_table | input | 32*N_CH | Handler address of channel c at bits [32c+31:32c] |
| phantom_addr | input | 32 | Vector returned when a class is empty |

## Verification
The bench builds the block with eight channels. With that size, a single request mask can place the highest and the lowest channel in opposite classes. It also keeps the full drain of a class down to nine reads, so the bench empties the pending latches completely between table entries. The vector table is filled with distinct computed addresses, so a vector that belongs to the wrong channel always shows as a mismatch.

// File: rtl/intvec_pkg.sv
package intvec_pkg;
  localparam int unsigned IDX_W  = 8;
  localparam int unsigned DATA_W = 32;

  localparam logic [7:0] OFF_NIDX = 8'h00;
  localparam logic [7:0] OFF_FIDX = 8'h04;
  localparam logic [7:0] OFF_NVEC = 8'h70;
  localparam logic [7:0] OFF_FVEC = 8'h74;

  typedef logic [IDX_W-1:0] idx_t;
endpackage

// File: rtl/intvec_pend.sv
module intvec_pend #(
  parameter int unsigned N_CH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] req,
  input  logic [N_CH-1:0] clr,
  output logic [N_CH-1:0] pend_q,
  output logic [N_CH-1:0] pend_d
);
  // a request seen in the same cycle as its clear keeps the latch set
  assign pend_d = (pend_q & ~clr) | req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_chk
      AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[i] && !clr[i]) |=> pend_q[i]); // R9
    end
  endgenerate
endmodule

// File: rtl/intvec_arb.sv
module intvec_arb
  import intvec_pkg::*;
#(
  parameter int unsigned N_CH    = 16,
  parameter bit          IS_FAST = 1'b0
) (
  input  logic [N_CH-1:0] pend,
  input  logic [N_CH-1:0] fast_sel,
  input  logic [N_CH-1:0] chan_en,
  output idx_t            win_idx
);
  logic [N_CH-1:0] elig;

  generate
    if (IS_FAST) begin : g_fast
      assign elig = pend & chan_en & fast_sel;
    end else begin : g_norm
      assign elig = pend & chan_en & ~fast_sel;
    end
  endgenerate

  // lowest channel wins; index 0 means nothing eligible
  always_comb begin
    win_idx = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (elig[i]) win_idx = idx_t'(i + 1);
    end
  end
endmodule

// File: rtl/intvec_reader.sv
module intvec_reader
  import intvec_pkg::*;
#(
  parameter int unsigned N_CH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_sel,
  input  logic                     bus_we,
  input  logic [7:0]               bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic [N_CH-1:0]          req,
  input  logic [N_CH-1:0]          fast_sel,
  input  logic [N_CH-1:0]          chan_en,
  input  logic [DATA_W*N_CH-1:0]   vec_table,
  input  logic [DATA_W-1:0]        phantom_addr
);
  localparam int unsigned CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic [N_CH-1:0] pend_q, pend_d, clr, clr_n, clr_f;
  idx_t            n_win, f_win, n_idx_q, f_idx_q;
  logic [CH_W-1:0] n_ch, f_ch;
  logic [DATA_W-1:0] vtab [N_CH];
  logic [DATA_W-1:0] n_vec, f_vec;
  logic            rd, rd_n, rd_f;
  logic            unused_wdata;

  assign unused_wdata = ^bus_wdata;

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_vt
      assign vtab[c] = vec_table[c*DATA_W +: DATA_W];
    end
  endgenerate

  intvec_pend #(.N_CH(N_CH)) u_pend (
    .clk(clk), .rst_n(rst_n), .req(req), .clr(clr),
    .pend_q(pend_q), .pend_d(pend_d)
  );

  intvec_arb #(.N_CH(N_CH), .IS_FAST(1'b0)) u_arb_n (
    .pend(pend_d), .fast_sel(fast_sel), .chan_en(chan_en), .win_idx(n_win)
  );

  intvec_arb #(.N_CH(N_CH), .IS_FAST(1'b1)) u_arb_f (
    .pend(pend_d), .fast_sel(fast_sel), .chan_en(chan_en), .win_idx(f_win)
  );

  // one registered result per class feeds both its index and its vector
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_idx_q <= '0;
      f_idx_q <= '0;
    end else begin
      n_idx_q <= n_win;
      f_idx_q <= f_win;
    end
  end

  assign n_ch  = n_idx_q[CH_W-1:0] - 1'b1;
  assign f_ch  = f_idx_q[CH_W-1:0] - 1'b1;
  assign n_vec = (n_idx_q == '0) ? phantom_addr : vtab[n_ch];
  assign f_vec = (f_idx_q == '0) ? phantom_addr : vtab[f_ch];

  assign rd   = bus_sel && !bus_we;
  assign rd_n = rd && (bus_addr == OFF_NIDX || bus_addr == OFF_NVEC);
  assign rd_f = rd && (bus_addr == OFF_FIDX || bus_addr == OFF_FVEC);

  always_comb begin
    clr_n = '0;
    clr_f = '0;
    if (rd_n && n_idx_q != '0) clr_n[n_ch] = 1'b1;
    if (rd_f && f_idx_q != '0) clr_f[f_ch] = 1'b1;
  end
  assign clr = clr_n | clr_f;

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      unique case (bus_addr)
        OFF_NIDX: bus_rdata = {{(DATA_W-IDX_W){1'b0}}, n_idx_q};
        OFF_FIDX: bus_rdata = {{(DATA_W-IDX_W){1'b0}}, f_idx_q};
        OFF_NVEC: bus_rdata = n_vec;
        OFF_FVEC: bus_rdata = f_vec;
        default:  bus_rdata = '0;
      endcase
    end
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (n_idx_q <= idx_t'(N_CH)) && (f_idx_q <= idx_t'(N_CH))); // R2
  AST_WIN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (n_idx_q != '0) |-> pend_q[n_ch]); // R2
  AST_CONSUME: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && n_idx_q != '0 && !req[n_ch]) |=> !pend_q[$past(n_ch)]); // R5
  AST_WRITE_NOCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we) |-> (clr == '0)); // R8
  AST_CLASS_SEP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(clr) <= 2); // R6
endmodule

// File: tb/tb_intvec_reader.sv
module tb_intvec_reader;
  localparam int N = 8;
  localparam logic [31:0] PH = 32'hDEAD_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] req = '0, fast_sel = '0, chan_en = '1;
  logic [32*N-1:0] vec_table;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  intvec_reader #(.N_CH(N)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req(req), .fast_sel(fast_sel), .chan_en(chan_en),
    .vec_table(vec_table), .phantom_addr(PH)
  );

  function automatic logic [31:0] vec(int c);
    return 32'h1000 + 32'(c) * 32'h10;
  endfunction

  typedef struct packed {
    logic [7:0]  rq;
    logic [7:0]  fs;
    logic [7:0]  en;
    logic [7:0]  ad;
    logic [31:0] ex;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{8'h0C, 8'h00, 8'hFF, 8'h00, 32'h3},          // R2
    '{8'h0C, 8'h00, 8'hFF, 8'h70, 32'h1020},       // R4
    '{8'h81, 8'h01, 8'hFF, 8'h04, 32'h1},          // R7 fast class
    '{8'h81, 8'h01, 8'hFF, 8'h00, 32'h8},          // R7 normal class
    '{8'h81, 8'h01, 8'hFF, 8'h74, 32'h1000},       // R4
    '{8'h0F, 8'h00, 8'hF0, 8'h00, 32'h0},          // R7 disabled
    '{8'h0F, 8'h00, 8'hF0, 8'h70, 32'hDEAD_0000},  // R3
    '{8'h30, 8'h10, 8'hFF, 8'h00, 32'h6},          // R7
    '{8'h30, 8'h10, 8'hFF, 8'h08, 32'h0},          // R8 unmapped
    '{8'h00, 8'h00, 8'hFF, 8'h04, 32'h0}           // R3
  };

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rd_chk(string rq, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(rq, d, exp);
  endtask

  task automatic pulse(logic [N-1:0] m);
    req = m;
    @(negedge clk);
    req = '0;
  endtask

  task automatic drain();
    logic [31:0] d;
    chan_en = '1; fast_sel = '0;
    @(negedge clk);
    for (int k = 0; k <= N; k++) rd(8'h00, d);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < N; c++) vec_table[c*32 +: 32] = vec(c);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk("R1", 8'h00, 32'h0);
    rd_chk("R1", 8'h04, 32'h0);
    rd_chk("R1", 8'h70, PH);
    rd_chk("R1", 8'h74, PH);

    // table walk
    for (int i = 0; i < 10; i++) begin
      fast_sel = TBL[i].fs; chan_en = TBL[i].en;
      pulse(TBL[i].rq);
      rd_chk($sformatf("R2/R4/R7 row %0d", i), TBL[i].ad, TBL[i].ex);
      drain();
    end

    // R5 consumption order, vector read also advances
    pulse(8'h16);
    rd_chk("R5", 8'h00, 32'h2);
    rd_chk("R5", 8'h70, vec(2));
    rd_chk("R5", 8'h00, 32'h5);
    rd_chk("R5", 8'h00, 32'h0);
    rd_chk("R3", 8'h70, PH);

    // R6 classes independent
    fast_sel = 8'h02;
    pulse(8'h03);
    rd_chk("R6", 8'h00, 32'h1);
    rd_chk("R6", 8'h00, 32'h0);
    rd_chk("R6", 8'h04, 32'h2);
    rd_chk("R6", 8'h74, PH);
    fast_sel = '0;

    // R8 write and unmapped read leave state untouched
    pulse(8'h04);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'h00; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    rd_chk("R8", 8'h08, 32'h0);
    rd_chk("R8", 8'h00, 32'h3);
    rd_chk("R8", 8'h00, 32'h0);

    // R9 held request re-pends; pulse stays latched
    req = 8'h40;
    @(negedge clk);
    rd_chk("R9", 8'h00, 32'h7);
    rd_chk("R9", 8'h00, 32'h7);
    req = '0;
    rd_chk("R9", 8'h00, 32'h7);
    rd_chk("R9", 8'h00, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule